// File: doc/BRIEF.md
# Run-Time Programmable Sum-of-Products Array

This block is a two-level logic array whose contents are loaded at run time. It has `N_IN` inputs, `N_TERM` product terms and `N_OUT` outputs. Each product term is the AND of a chosen set of input literals. Each output is the OR of the terms routed to it. A single term can be routed to any number of outputs, so logic that two outputs share is stored once.

The array is loaded through a write port, one term per write. One write carries a term index, the literal codes for that term (the AND row) and the routing bits for that term (the OR row). After that the block turns its inputs into outputs. A per-output enable can mask any output to zero.

The result goes through an output register when `OUT_REG` is 1, which is the default. With `OUT_REG` at 0 the path from input to output is purely combinational.

Top module: `cfg_pla`

## Requirements
- R1: Each input owns a 2-bit literal field at bits [2i+1:2i] of the AND row. 01 means the term needs the input high. 10 means the term needs the input low. 11 forces the term to 0 whatever the inputs are.
- R2: A term whose literal fields are all 00 (don't-care) evaluates to 1.
- R3: Bit j of a term's OR row routes that term to output j. Each output is the OR of all terms routed to it.
- R4: One stored term can drive several outputs at once and gives the same value to each of them.
- R5: A term whose OR row is all zero has no effect on any output.
- R6: A write stores the term at the clock edge where `cfg_we` is high. With `OUT_REG`=1, the output registered at that same edge still uses the old contents. The new contents show up at the next edge.
- R7: Synchronous reset clears every OR row and the output register. All outputs read 0 until terms are loaded.
- R8: When `out_en[j]` is 0, output j is 0. With `OUT_REG`=1 the enable is sampled with the inputs, one edge before the output shows it.
- R9: A write whose term index is `N_TERM` or larger changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for one term |
| cfg_row | input | IDX_W | Index of the term to write |
| cfg_and | input | 2*N_IN | Literal codes of the term, 2 bits per input |
| cfg_or | input | N_OUT | Output routing bits of the term |
| in_vec | input | N_IN | Logic inputs |
| out_en | input | N_OUT | Per-output enable |
| f_out | output | N_OUT | Sum-of-products results |

## Verification
A term can be written in the same cycle that the registered output samples the array. The bench provokes this on purpose by changing a term while the inputs it depends on are applied. Two cycles are checked. The output at the write edge must match a shadow model taken before the write, and the output one edge later must match the model taken after it. Random traffic keeps writes and evaluation overlapping. Directed cases cover the same conflict on an all-don't-care term, where the output flips between those two edges.

// File: rtl/pla_pkg.sv
package pla_pkg;

  typedef enum logic [1:0] {
    LIT_IGNORE = 2'b00,
    LIT_TRUE   = 2'b01,
    LIT_COMPL  = 2'b10,
    LIT_KILL   = 2'b11
  } lit_e;

  // Contribution of one literal cell to its product term.
  function automatic logic lit_pass(input lit_e code, input logic v);
    logic r;
    unique case (code)
      LIT_IGNORE: r = 1'b1;
      LIT_TRUE:   r = v;
      LIT_COMPL:  r = ~v;
      default:    r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pla_and_plane.sv
module pla_and_plane
  import pla_pkg::*;
#(
  parameter  int N_IN   = 4,
  parameter  int N_TERM = 8,
  localparam int ROW_W  = 2 * N_IN,
  localparam int IDX_W  = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [IDX_W-1:0]          row,
  input  logic [ROW_W-1:0]          row_code,
  input  logic [N_IN-1:0]           x,
  output logic [N_TERM-1:0]         term,
  output logic [N_TERM*ROW_W-1:0]   plane_flat
);

  // Literal storage, one row per term; no reset so it maps to RAM.
  logic [ROW_W-1:0] lit_q [N_TERM];

  always_ff @(posedge clk) begin
    if (we && (int'(row) < N_TERM)) begin
      lit_q[row] <= row_code;
    end
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] hit;
    for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign hit[i] = lit_pass(lit_e'(lit_q[t][2*i +: 2]), x[i]);
    end
    assign term[t] = &hit;
    assign plane_flat[t*ROW_W +: ROW_W] = lit_q[t];
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter  int N_TERM = 8,
  parameter  int N_OUT  = 4,
  localparam int IDX_W  = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      we,
  input  logic [IDX_W-1:0]          row,
  input  logic [N_OUT-1:0]          row_bits,
  input  logic [N_TERM-1:0]         term,
  input  logic [N_OUT-1:0]          en,
  output logic [N_OUT-1:0]          y,
  output logic [N_TERM*N_OUT-1:0]   plane_flat
);

  logic [N_OUT-1:0] conn_q [N_TERM];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int t = 0; t < N_TERM; t++) begin
        conn_q[t] <= '0;
      end
    end else if (we && (int'(row) < N_TERM)) begin
      conn_q[row] <= row_bits;
    end
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_sum
    logic acc;
    always_comb begin
      acc = 1'b0;
      for (int t = 0; t < N_TERM; t++) begin
        acc = acc | (term[t] & conn_q[t][j]);
      end
    end
    assign y[j] = acc & en[j];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_flat
    assign plane_flat[t*N_OUT +: N_OUT] = conn_q[t];
  end

endmodule

// File: rtl/pla_out_stage.sv
module pla_out_stage #(
  parameter int WIDTH   = 4,
  parameter bit OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= d;
    end
  end else begin : g_comb
    logic unused_ok;
    assign unused_ok = clk ^ rst;
    assign q = d;
  end

endmodule

// File: rtl/cfg_pla.sv
module cfg_pla #(
  parameter  int N_IN    = 4,
  parameter  int N_TERM  = 8,
  parameter  int N_OUT   = 4,
  parameter  bit OUT_REG = 1'b1,
  localparam int ROW_W   = 2 * N_IN,
  localparam int IDX_W   = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_row,
  input  logic [ROW_W-1:0]   cfg_and,
  input  logic [N_OUT-1:0]   cfg_or,
  input  logic [N_IN-1:0]    in_vec,
  input  logic [N_OUT-1:0]   out_en,
  output logic [N_OUT-1:0]   f_out
);

  logic [N_TERM-1:0]        term;
  logic [N_OUT-1:0]         sum;
  logic [N_TERM*ROW_W-1:0]  and_flat;
  logic [N_TERM*N_OUT-1:0]  or_flat;

  pla_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .clk        (clk),
    .we         (cfg_we),
    .row        (cfg_row),
    .row_code   (cfg_and),
    .x          (in_vec),
    .term       (term),
    .plane_flat (and_flat)
  );

  pla_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT)) u_or (
    .clk        (clk),
    .rst        (rst),
    .we         (cfg_we),
    .row        (cfg_row),
    .row_bits   (cfg_or),
    .term       (term),
    .en         (out_en),
    .y          (sum),
    .plane_flat (or_flat)
  );

  pla_out_stage #(.WIDTH(N_OUT), .OUT_REG(OUT_REG)) u_out (
    .clk (clk),
    .rst (rst),
    .d   (sum),
    .q   (f_out)
  );

endmodule

// File: rtl/cfg_pla_chk.sv
module cfg_pla_chk #(
  parameter  int N_IN    = 4,
  parameter  int N_TERM  = 8,
  parameter  int N_OUT   = 4,
  parameter  bit OUT_REG = 1'b1,
  localparam int ROW_W   = 2 * N_IN
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      cfg_we,
  input logic [N_OUT-1:0]          out_en,
  input logic [N_OUT-1:0]          f_out,
  input logic [N_TERM*ROW_W-1:0]   and_flat,
  input logic [N_TERM*N_OUT-1:0]   or_flat
);

  // Per-term classification taken from the stored planes.
  logic [N_TERM-1:0] t_dead;
  logic [N_TERM-1:0] t_free;
  logic [N_OUT-1:0]  must_one;
  logic [N_OUT-1:0]  must_zero;

  always_comb begin
    for (int t = 0; t < N_TERM; t++) begin
      t_dead[t] = 1'b0;
      t_free[t] = 1'b1;
      for (int i = 0; i < N_IN; i++) begin
        if (and_flat[t*ROW_W + 2*i +: 2] == 2'b11) t_dead[t] = 1'b1;
        if (and_flat[t*ROW_W + 2*i +: 2] != 2'b00) t_free[t] = 1'b0;
      end
    end
    for (int j = 0; j < N_OUT; j++) begin
      must_one[j]  = 1'b0;
      must_zero[j] = 1'b1;
      for (int t = 0; t < N_TERM; t++) begin
        if (or_flat[t*N_OUT + j]) begin
          if (t_free[t]) must_one[j] = 1'b1;
          if (!t_dead[t]) must_zero[j] = 1'b0;
        end
      end
    end
  end

  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (f_out == '0));

  p_plane_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_we) |-> ($stable(or_flat) && $stable(and_flat)));

  if (OUT_REG) begin : g_reg_chk
    for (genvar j = 0; j < N_OUT; j++) begin : g_o
      p_free_term_r2: assert property (@(posedge clk) disable iff (rst)
        $past(must_one[j] & out_en[j]) |-> f_out[j]);
      p_killed_terms_r1: assert property (@(posedge clk) disable iff (rst)
        $past(must_zero[j]) |-> !f_out[j]);
      p_enable_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !$past(out_en[j]) |-> !f_out[j]);
    end
  end else begin : g_comb_chk
    for (genvar j = 0; j < N_OUT; j++) begin : g_o
      p_free_term_r2: assert property (@(posedge clk) disable iff (rst)
        (must_one[j] & out_en[j]) |-> f_out[j]);
      p_killed_terms_r1: assert property (@(posedge clk) disable iff (rst)
        must_zero[j] |-> !f_out[j]);
      p_enable_gate_r8: assert property (@(posedge clk) disable iff (rst)
        !out_en[j] |-> !f_out[j]);
    end
  end

endmodule

bind cfg_pla cfg_pla_chk #(
  .N_IN    (N_IN),
  .N_TERM  (N_TERM),
  .N_OUT   (N_OUT),
  .OUT_REG (OUT_REG)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_we   (cfg_we),
  .out_en   (out_en),
  .f_out    (f_out),
  .and_flat (and_flat),
  .or_flat  (or_flat)
);

// File: tb/cfg_pla_tb.sv
module cfg_pla_tb;

  localparam int N  = 4;
  localparam int P  = 12;
  localparam int M  = 4;
  localparam int IW = $clog2(P);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            cfg_we = 1'b0;
  logic [IW-1:0]   cfg_row = '0;
  logic [2*N-1:0]  cfg_and = '0;
  logic [M-1:0]    cfg_or = '0;
  logic [N-1:0]    in_vec = '0;
  logic [M-1:0]    out_en = '1;
  logic [M-1:0]    f_out;

  int n_vec  = 0;
  int n_bad  = 0;
  bit done   = 1'b0;

  logic [2*N-1:0] sh_and [P];
  logic [M-1:0]   sh_or  [P];

  always #5 clk = ~clk;

  cfg_pla #(.N_IN(N), .N_TERM(P), .N_OUT(M), .OUT_REG(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_row(cfg_row),
    .cfg_and(cfg_and), .cfg_or(cfg_or), .in_vec(in_vec),
    .out_en(out_en), .f_out(f_out)
  );

  // Pattern text, leftmost char = in_vec[N-1]: 1 true, 0 complement, - ignore, x kill (R1).
  function automatic logic [2*N-1:0] pat(input string s);
    logic [2*N-1:0] r = '0;
    for (int k = 0; k < N; k++) begin
      int i = N - 1 - k;
      case (s[k])
        "1": r[2*i +: 2] = 2'b01;
        "0": r[2*i +: 2] = 2'b10;
        "x": r[2*i +: 2] = 2'b11;
        default: r[2*i +: 2] = 2'b00;
      endcase
    end
    return r;
  endfunction

  function automatic logic [M-1:0] model(input logic [N-1:0] x, input logic [M-1:0] en);
    logic [M-1:0] r = '0;
    for (int t = 0; t < P; t++) begin
      logic hit = 1'b1;
      for (int i = 0; i < N; i++) begin
        case (sh_and[t][2*i +: 2])
          2'b01: hit &= x[i];
          2'b10: hit &= ~x[i];
          2'b11: hit = 1'b0;
          default: ;
        endcase
      end
      if (hit) r |= sh_or[t];
    end
    return r & en;
  endfunction

  // BCD code to the W X Y Z reflected code, W in bit 3.
  function automatic logic [3:0] gray_ref(input int v);
    case (v)
      0: return 4'b0000;  1: return 4'b0001;  2: return 4'b0011;
      3: return 4'b0010;  4: return 4'b0110;  5: return 4'b1110;
      6: return 4'b1010;  7: return 4'b1011;  8: return 4'b1001;
      default: return 4'b1000;
    endcase
  endfunction

  // O0=AB+B'C', O1=B'C+A, O2=AB+AC', O3=B'C+AC'+B'C' with A,B,C = in[2:0].
  function automatic logic [3:0] share_ref(input logic [N-1:0] x);
    logic a = x[2], b = x[1], c = x[0];
    return { (~b & c) | (a & ~c) | (~b & ~c),
             (a & b) | (a & ~c),
             (~b & c) | a,
             (a & b) | (~b & ~c) };
  endfunction

  task automatic check(input string req, input logic [M-1:0] got, input logic [M-1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: f_out=%b expected=%b", req, got, exp);
    end
  endtask

  // One clock: drive at negedge, sample the registered result at the following negedge.
  task automatic cycle(input logic we, input int row, input logic [2*N-1:0] ac,
                       input logic [M-1:0] ob, input logic [N-1:0] x,
                       input logic [M-1:0] en, input string req,
                       output logic [M-1:0] got);
    logic [M-1:0] exp;
    cfg_we = we; cfg_row = IW'(row); cfg_and = ac; cfg_or = ob;
    in_vec = x; out_en = en;
    exp = model(x, en);
    @(posedge clk);
    if (we && row < P) begin sh_and[row] = ac; sh_or[row] = ob; end
    @(negedge clk);
    cfg_we = 1'b0;
    got = f_out;
    check(req, got, exp);
  endtask

  task automatic wr(input int row, input string s, input logic [M-1:0] ob);
    logic [M-1:0] g;
    cycle(1'b1, row, pat(s), ob, '0, '1, "R6", g);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: f_out=%b expected=done", f_out);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [M-1:0] g;
    void'($urandom(32'd1357));
    for (int t = 0; t < P; t++) begin sh_and[t] = '0; sh_or[t] = '0; end

    // R7: outputs clear during and after reset, before any load.
    repeat (3) @(negedge clk);
    check("R7", f_out, '0);
    rst = 1'b0;
    for (int k = 0; k < 4; k++) begin
      cycle(1'b0, 0, '0, '0, N'($urandom), '1, "R7", g);
      check("R7", g, '0);
    end

    // BCD to reflected code; term 3 (BC') shared by X and Y (R3, R4).
    wr(0, "1---", 4'b1000);
    wr(1, "-1-1", 4'b1000);
    wr(2, "-11-", 4'b1000);
    wr(3, "-10-", 4'b0110);
    wr(4, "--1-", 4'b0010);
    wr(5, "1--0", 4'b0001);
    wr(6, "0001", 4'b0001);
    wr(7, "-111", 4'b0001);
    wr(8, "-010", 4'b0001);
    for (int v = 0; v < 10; v++) begin
      cycle(1'b0, 0, '0, '0, N'(v), '1, "R3", g);
      check("R4", g, gray_ref(v));
    end

    // R5: free term with no routing leaves outputs alone.
    wr(9, "----", 4'b0000);
    cycle(1'b0, 0, '0, '0, 4'd3, '1, "R5", g);
    check("R5", g, gray_ref(3));

    // R6: write during evaluation; old value at the write edge, new after.
    cycle(1'b1, 10, pat("----"), 4'b0001, 4'd3, '1, "R6", g);
    check("R6", g, gray_ref(3));
    cycle(1'b0, 0, '0, '0, 4'd3, '1, "R2", g);
    check("R2", g, 4'b0011);

    // R1: one killed literal removes the free term.
    wr(10, "--x-", 4'b0001);
    cycle(1'b0, 0, '0, '0, 4'd3, '1, "R1", g);
    check("R1", g, 4'b0010);
    wr(10, "-0--", 4'b0100);
    cycle(1'b0, 0, '0, '0, 4'd1, '1, "R1", g);
    check("R1", g, 4'b0101);
    wr(10, "----", 4'b0000);

    // R9: index past the last term is dropped.
    cycle(1'b1, 13, pat("----"), 4'b1111, 4'd0, '1, "R9", g);
    cycle(1'b0, 0, '0, '0, 4'd0, '1, "R9", g);
    check("R9", g, 4'b0000);

    // R8: masked outputs read 0.
    cycle(1'b0, 0, '0, '0, 4'd5, 4'b0101, "R8", g);
    check("R8", g, 4'b0100);

    // R4: shared-term set on three inputs.
    for (int t = 0; t < P; t++) wr(t, "----", 4'b0000);
    wr(0, "-11-", 4'b0101);
    wr(1, "--01", 4'b1010);
    wr(2, "-1-0", 4'b1100);
    wr(3, "--00", 4'b1001);
    wr(4, "-1--", 4'b0010);
    for (int v = 0; v < 16; v++) begin
      cycle(1'b0, 0, '0, '0, N'(v), '1, "R4", g);
      check("R4", g, share_ref(N'(v)));
    end

    // R3/R6/R9: random loads overlapping evaluation, including rows past the end.
    for (int k = 0; k < 600; k++) begin
      logic [2*N-1:0] ac;
      for (int i = 0; i < N; i++) begin
        int r = $urandom_range(0, 15);
        ac[2*i +: 2] = (r < 6) ? 2'b00 : (r < 10) ? 2'b01 : (r < 15) ? 2'b10 : 2'b11;
      end
      cycle(($urandom_range(0, 2) == 0), $urandom_range(0, 15), ac, M'($urandom),
            N'($urandom), ($urandom_range(0, 4) == 0) ? M'($urandom) : '1, "R3", g);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule